// File: doc/BRIEF.md
# Eight-Bit Addressable Latch and Demultiplexer

This block holds eight output bits. A 3-bit select, a single data bit and two active-low mode pins control it. The two mode pins pick one of four behaviours:

- **Write:** store the data bit into the one selected bit.
- **Hold:** keep every bit as it is.
- **Steer:** drive the data bit onto the selected output and zero every other output.
- **Clear:** zero every output.

The block is the clocked counterpart of a transparent bit-addressable latch. Every mode takes effect on the rising clock edge, and the registered outputs show the result one cycle after the inputs are presented. A separate active-low power-on reset clears all bits asynchronously, whatever the mode pins show. Users should change the select only while in hold mode. In this clocked form a select change during write mode is still safe, because only the value sampled at the edge counts.

Top module: `addr_bit_latch`

## Requirements
- R1: With `strobe_n`=0 and `clear_n`=1 (write mode), the bit of `q` selected by `sel` takes the value of `din` at the rising edge.
- R2: In write mode, every bit of `q` other than the selected one keeps its previous value.
- R3: With `strobe_n`=1 and `clear_n`=1 (hold mode), `q` keeps its previous value whatever `sel` and `din` do.
- R4: With `strobe_n`=0 and `clear_n`=0 (steer mode), the selected bit of `q` equals `din` and all other bits are 0.
- R5: With `strobe_n`=1 and `clear_n`=0 (clear mode), all bits of `q` become 0 whatever `sel` and `din` are.
- R6: `sel` is plain binary with bit 0 as its least significant bit, and value k selects `q[k]`. So 0 selects `q[0]` and 7 selects `q[7]`.
- R7: `q` changes only at a rising clock edge. An input change does not alter `q` before the next edge.
- R8: When the block enters hold mode from steer or clear mode, it keeps the outputs produced in that last steer or clear cycle.
- R9: While `rst_n`=0, `q` is all zeros at once and stays so, overriding every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strobe_n | input | 1 | Active-low mode pin: write or steer when low |
| clear_n | input | 1 | Active-low mode pin: steer or clear when low |
| sel | input | 3 | Bit select, binary |
| din | input | 1 | Data bit |
| q | output | 8 | Stored or steered output bits |

## Verification
Two functions can fall in the same cycle: a write-mode update of the selected bit, and the power-on reset. The bench provokes this by pulling `rst_n` low while `strobe_n` is low, `clear_n` is high and `din` is 1. The outputs must read zero both during and after that edge, so the reset wins. A second clash occurs when steer mode is followed directly by hold mode with a new select and data. That case is judged by whether the steered pattern survives unchanged rather than being rewritten from the new inputs.

// File: rtl/addr_bit_latch.sv
module addr_bit_latch #(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_n,
  input  logic             clear_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic [NBITS-1:0] q
);

  logic [NBITS-1:0] pick;
  logic [NBITS-1:0] nxt;

  assign pick = {{(NBITS-1){1'b0}}, 1'b1} << sel;

  always_comb begin
    unique case ({strobe_n, clear_n})
      2'b01:   nxt = din ? (q | pick) : (q & ~pick);
      2'b11:   nxt = q;
      2'b00:   nxt = din ? pick : '0;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/addr_bit_latch_chk.sv
module addr_bit_latch_chk #(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_n,
  input logic             clear_n,
  input logic [SEL_W-1:0] sel,
  input logic             din,
  input logic [NBITS-1:0] q
);

  // R1
  write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && clear_n) |=> q[$past(sel)] == $past(din));

  // R2
  write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && clear_n) |=>
      $countones((q ^ $past(q)) & ~(NBITS'(1) << $past(sel))) == 0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && clear_n) |=> $stable(q));

  // R4
  steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !clear_n) |=>
      (q == ($past(din) ? (NBITS'(1) << $past(sel)) : NBITS'(0))));

  // R4
  steer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !clear_n) |=> $onehot0(q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && !clear_n) |=> q == '0);

  // R9
  por_chk: assert property (@(posedge clk) !rst_n |-> q == '0);

endmodule

bind addr_bit_latch addr_bit_latch_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .clear_n(clear_n),
  .sel(sel), .din(din), .q(q)
);

// File: tb/tb_addr_bit_latch.sv
module tb_addr_bit_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic       clear_n = 1'b1;
  logic [2:0] sel = '0;
  logic       din = 1'b0;
  logic [7:0] q;
  logic [7:0] model = '0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_bit_latch dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .clear_n(clear_n),
    .sel(sel), .din(din), .q(q)
  );

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%02h expected %02h", tag, q, exp);
    end
  endtask

  task automatic step(input logic sn, input logic cn, input logic [2:0] a, input logic d);
    string tag;
    strobe_n = sn; clear_n = cn; sel = a; din = d;
    #1 check("R7 no change before edge", model);
    @(posedge clk);
    case ({sn, cn})
      2'b01: begin model[a] = d; tag = "R1,R2,R6 write"; end
      2'b11: tag = "R3 hold";
      2'b00: begin model = d ? (8'd1 << a) : 8'd0; tag = "R4,R6 steer"; end
      default: begin model = 8'd0; tag = "R5 clear"; end
    endcase
    @(negedge clk);
    check(tag, model);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    @(negedge clk);
    check("R9 reset state", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int d = 0; d < 2; d++) begin
          step(m[1], m[0], a[2:0], d[0] ^ a[0]);
        end
      end
      for (int a = 0; a < 8; a++) step(1'b0, 1'b1, a[2:0], a[1]);
    end
    // R8: steer then hold with new inputs
    step(1'b0, 1'b0, 3'd5, 1'b1);
    step(1'b1, 1'b1, 3'd2, 1'b0);
    check("R8 hold after steer", 8'h20);
    step(1'b1, 1'b0, 3'd7, 1'b1);
    step(1'b1, 1'b1, 3'd7, 1'b1);
    check("R8 hold after clear", 8'h00);
    lfsr = 8'hA7;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] & lfsr[7], lfsr[1] | lfsr[6], lfsr[4:2], lfsr[5]);
    end
    // R9: power-on reset collides with a write
    for (int a = 0; a < 8; a++) step(1'b0, 1'b1, a[2:0], 1'b1);
    check("R9 preload", 8'hFF);
    strobe_n = 1'b0; clear_n = 1'b1; sel = 3'd3; din = 1'b1;
    rst_n = 1'b0;
    #1 check("R9 immediate clear", 8'h00);
    @(negedge clk);
    check("R9 reset beats write", 8'h00);
    rst_n = 1'b1;
    model = 8'h00;
    @(negedge clk);
    model[3] = 1'b1;
    check("R1 write after reset", model);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule